// File: doc/BRIEF.md
# Serial EEPROM mode and autoload controller

This block owns an 8-bit command register whose top two bits choose how a device talks to a Microwire serial EEPROM with 16-bit words. In run mode the device works normally and the EEPROM pins stay idle. In load mode a sequencer reads a fixed number of words from the EEPROM, starting at address 0, and hands each word to the configuration logic on a valid/ready stream. When the last word has been taken, the mode field drops back to run mode by itself and a one-cycle soft-reset pulse tells the rest of the chip to return its registers to their defaults. In program mode software drives chip select, serial clock and data-in directly through register bits and reads data-out back. Host and network operation are disabled in this mode. In unlock mode a config-write-enable output lets writes reach the protected configuration registers.

The load stream follows these rules. `ld_valid` rises with a complete word and its address. Word and address stay unchanged while `ld_ready` is low. A word is taken in a cycle where both are high. The sequencer holds chip select low and stops the serial clock until the word is taken, so back-pressure can last any number of cycles without corrupting a read. Register writes are single-cycle strobes with no handshake. `reg_rdata` is a continuous combinational view of the register.

Top module: `eeload_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, `ee_cs`, `ee_sk` and `ee_di` are low, `net_en` is high, and `cfg_wr_en`, `ld_valid` and `soft_rst` are low.
- R2: Bits 7:6 of a write select the mode: 00 run, 01 load, 10 program, 11 unlock. The mode reads back in bits 7:6 from the cycle after the write. Bits 5:4 always read 0, and writing them has no effect.
- R3: `cfg_wr_en` is high exactly while the mode is 11.
- R4: While the mode is 10, `net_en` is low, and `ee_cs`, `ee_sk` and `ee_di` follow write bits 3, 2 and 1. Read bits 3:1 show those pins and read bit 0 shows the live `ee_do` input. `net_en` is high in every other mode.
- R5: Bit 0 is read-only. The value written to it has no effect, and in modes 10 and 01 it always reads the current `ee_do`.
- R6: In modes 00 and 11, `ee_cs`, `ee_sk` and `ee_di` are low and read bits 3:0 are 0. Pin bits written along with one of these modes are discarded.
- R7: Writing mode 01 starts a load of addresses 0 to NUM_WORDS-1 in order. Each address is read with its own chip-select window, which sends a start bit 1, opcode 10 and a 6-bit address, MSB first. The EEPROM answers with a dummy 0 and then 16 data bits, MSB first. Each data bit is sampled just before the next rising serial-clock edge.
- R8: Each loaded word appears on `ld_data` with its address on `ld_addr` and `ld_valid` high. Both stay stable until `ld_ready` is seen high.
- R9: While the mode is 01, register writes are ignored. The mode reads 01, and read bits 3:0 show `ee_cs`, `ee_sk`, `ee_di` and `ee_do`.
- R10: When the last word is taken, the mode returns to 00 and `soft_rst` is high for exactly one cycle. That cycle is the first one in which the register reads 00 with pin bits 0.
- R11: Every high phase of `ee_sk` during a load lasts CLK_HALF clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read view |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Data to the EEPROM |
| ee_do | input | 1 | Data from the EEPROM |
| net_en | output | 1 | Host and network operation enable |
| cfg_wr_en | output | 1 | Protected configuration write enable |
| soft_rst | output | 1 | One-cycle reset pulse at load completion |
| ld_valid | output | 1 | Loaded word valid |
| ld_ready | input | 1 | Loaded word accepted |
| ld_addr | output | 6 | EEPROM address of the loaded word |
| ld_data | output | 16 | Loaded word |

## Verification
The bench drives a behavioural EEPROM from the pins. It checks every received command and every streamed word against a memory image seeded at random, while `ld_ready` toggles at random. A design that skipped the dummy bit would deliver every word shifted by one bit. A design that let data move under back-pressure would lose or repeat words. A design that acted on a mode write made during a load would unlock configuration writes, or abandon the load half done. The bench also checks that the soft-reset pulse is a single cycle aligned with the return to mode 00, that bit 0 tracks `ee_do` whatever is written to it, and that a load started straight from program mode still reads address 0 first.

// File: rtl/eeload_pkg.sv
package eeload_pkg;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_LOAD   = 2'b01,
    MODE_PROG   = 2'b10,
    MODE_UNLOCK = 2'b11
  } ee_mode_e;

  typedef enum logic [2:0] {
    RD_IDLE,
    RD_SEL,
    RD_LOW,
    RD_HIGH,
    RD_DESEL,
    RD_PUSH,
    RD_DONE
  } rd_state_e;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } ee_pins_t;

endpackage

// File: rtl/eeload_cmd_reg.sv
module eeload_cmd_reg
  import eeload_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  logic [1:0] wmode,
  input  ee_pins_t wpins,
  input  logic     load_done,
  output ee_mode_e mode_o,
  output ee_pins_t sw_pins_o,
  output logic     load_start_o,
  output logic     soft_rst_o
);

  ee_mode_e mode_q;
  ee_pins_t pins_q;
  logic     soft_q;
  logic     wr_ok;

  // a write is honoured only when no load is running
  assign wr_ok        = wr && (mode_q != MODE_LOAD);
  assign load_start_o = wr_ok && (ee_mode_e'(wmode) == MODE_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      pins_q <= '0;
      soft_q <= 1'b0;
    end else begin
      soft_q <= load_done;
      if (load_done) begin
        mode_q <= MODE_RUN;
        pins_q <= '0;
      end else if (wr_ok) begin
        mode_q <= ee_mode_e'(wmode);
        pins_q <= (ee_mode_e'(wmode) == MODE_PROG) ? wpins : '0;
      end
    end
  end

  assign mode_o     = mode_q;
  assign sw_pins_o  = pins_q;
  assign soft_rst_o = soft_q;

endmodule

// File: rtl/eeload_mw_reader.sv
module eeload_mw_reader
  import eeload_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 8,
  parameter int CLK_HALF  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ee_do,
  output ee_pins_t          pins_o,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [WORD_W-1:0] ld_data,
  output logic              done
);

  localparam int CMD_BITS     = 3 + ADDR_W;
  localparam int SAMPLE_FIRST = CMD_BITS + 1;
  localparam int PULSES       = CMD_BITS + 1 + WORD_W;
  localparam int PW           = $clog2(PULSES);
  localparam int HCW          = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [PW-1:0]     LAST_P    = PW'(PULSES - 1);
  localparam logic [PW-1:0]     FIRST_S   = PW'(SAMPLE_FIRST);
  localparam logic [HCW-1:0]    HALF_LAST = HCW'(CLK_HALF - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

  rd_state_e           st;
  logic [HCW-1:0]      hcnt;
  logic [PW-1:0]       pidx;
  logic [ADDR_W-1:0]   addr;
  logic [WORD_W-1:0]   shreg;
  logic                half_end;
  logic [CMD_BITS-1:0] cmd_word;
  logic [CMD_BITS-1:0] cmd_sh;

  assign half_end = (hcnt == HALF_LAST);
  assign cmd_word = {3'b110, addr};
  assign cmd_sh   = cmd_word << pidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RD_IDLE;
      hcnt  <= '0;
      pidx  <= '0;
      addr  <= '0;
      shreg <= '0;
    end else begin
      case (st)
        RD_IDLE: begin
          if (start) begin
            st   <= RD_SEL;
            hcnt <= '0;
            addr <= '0;
          end
        end
        RD_SEL: begin
          if (half_end) begin
            hcnt <= '0;
            pidx <= '0;
            st   <= RD_LOW;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        RD_LOW: begin
          if (half_end) begin
            hcnt <= '0;
            if (pidx >= FIRST_S) shreg <= {shreg[WORD_W-2:0], ee_do};
            st <= RD_HIGH;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        RD_HIGH: begin
          if (half_end) begin
            hcnt <= '0;
            if (pidx == LAST_P) begin
              st <= RD_DESEL;
            end else begin
              pidx <= pidx + 1'b1;
              st   <= RD_LOW;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        RD_DESEL: begin
          if (half_end) begin
            hcnt <= '0;
            st   <= RD_PUSH;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        RD_PUSH: begin
          if (ld_ready) begin
            if (addr == LAST_ADDR) begin
              st <= RD_DONE;
            end else begin
              addr <= addr + 1'b1;
              st   <= RD_SEL;
            end
          end
        end
        RD_DONE: st <= RD_IDLE;
        default: st <= RD_IDLE;
      endcase
    end
  end

  always_comb begin
    pins_o    = '0;
    pins_o.cs = (st == RD_SEL) || (st == RD_LOW) || (st == RD_HIGH);
    pins_o.sk = (st == RD_HIGH);
    pins_o.di = ((st == RD_LOW) || (st == RD_HIGH)) && cmd_sh[CMD_BITS-1];
  end

  assign ld_valid = (st == RD_PUSH);
  assign ld_addr  = addr;
  assign ld_data  = shreg;
  assign done     = (st == RD_DONE);

endmodule

// File: rtl/eeload_pin_mux.sv
module eeload_pin_mux
  import eeload_pkg::*;
(
  input  ee_mode_e   mode,
  input  ee_pins_t   sw_pins,
  input  ee_pins_t   rd_pins,
  input  logic       ee_do,
  output ee_pins_t   pins_o,
  output logic [3:0] rd_bits,
  output logic       net_en,
  output logic       cfg_wr_en
);

  always_comb begin
    case (mode)
      MODE_LOAD: pins_o = rd_pins;
      MODE_PROG: pins_o = sw_pins;
      default:   pins_o = '0;
    endcase
  end

  assign rd_bits   = ((mode == MODE_LOAD) || (mode == MODE_PROG)) ?
                     {pins_o.cs, pins_o.sk, pins_o.di, ee_do} : 4'b0000;
  assign net_en    = (mode != MODE_PROG);
  assign cfg_wr_en = (mode == MODE_UNLOCK);

endmodule

// File: rtl/eeload_ctrl.sv
module eeload_ctrl
  import eeload_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 8,
  parameter int CLK_HALF  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do,
  output logic              net_en,
  output logic              cfg_wr_en,
  output logic              soft_rst,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [WORD_W-1:0] ld_data
);

  ee_mode_e   mode;
  ee_pins_t   sw_pins;
  ee_pins_t   rd_pins;
  ee_pins_t   pins;
  logic       load_start;
  logic       load_done;
  logic [3:0] rd_bits;
  logic       unused_wbits;

  assign unused_wbits = ^{reg_wdata[5:4], reg_wdata[0]};

  eeload_cmd_reg u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (reg_wr),
    .wmode        (reg_wdata[7:6]),
    .wpins        (ee_pins_t'(reg_wdata[3:1])),
    .load_done    (load_done),
    .mode_o       (mode),
    .sw_pins_o    (sw_pins),
    .load_start_o (load_start),
    .soft_rst_o   (soft_rst)
  );

  eeload_mw_reader #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .CLK_HALF  (CLK_HALF)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (load_start),
    .ee_do    (ee_do),
    .pins_o   (rd_pins),
    .ld_valid (ld_valid),
    .ld_ready (ld_ready),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .done     (load_done)
  );

  eeload_pin_mux u_mux (
    .mode      (mode),
    .sw_pins   (sw_pins),
    .rd_pins   (rd_pins),
    .ee_do     (ee_do),
    .pins_o    (pins),
    .rd_bits   (rd_bits),
    .net_en    (net_en),
    .cfg_wr_en (cfg_wr_en)
  );

  assign ee_cs     = pins.cs;
  assign ee_sk     = pins.sk;
  assign ee_di     = pins.di;
  assign reg_rdata = {mode, 2'b00, rd_bits};

endmodule

// File: rtl/eeload_ctrl_chk.sv
module eeload_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [7:0]        reg_rdata,
  input logic              ee_cs,
  input logic              ee_sk,
  input logic              ee_di,
  input logic              net_en,
  input logic              cfg_wr_en,
  input logic              soft_rst,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [WORD_W-1:0] ld_data
);

  a_r3_unlock_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en == (reg_rdata[7:6] == 2'b11));

  a_r4_prog_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7:6] == 2'b10) == !net_en);

  a_r6_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7:6] == 2'b00 || reg_rdata[7:6] == 2'b11) |->
      (!ee_cs && !ee_sk && !ee_di && reg_rdata[3:0] == 4'b0000));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5:4] == 2'b00);

  a_r7_stream_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (reg_rdata[7:6] == 2'b01));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |=> (ld_valid && $stable(ld_data) && $stable(ld_addr)));

  a_r9_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_rdata[7:6] == 2'b01) |=> (reg_rdata[7:6] == 2'b01 || soft_rst));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  a_r10_pulse_at_return: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (reg_rdata == 8'h00 && $past(reg_rdata[7:6]) == 2'b01));

endmodule

bind eeload_ctrl eeload_ctrl_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .ee_cs     (ee_cs),
  .ee_sk     (ee_sk),
  .ee_di     (ee_di),
  .net_en    (net_en),
  .cfg_wr_en (cfg_wr_en),
  .soft_rst  (soft_rst),
  .ld_valid  (ld_valid),
  .ld_ready  (ld_ready),
  .ld_addr   (ld_addr),
  .ld_data   (ld_data)
);

// File: tb/eeload_ctrl_bench.sv
`timescale 1ns/1ps
module eeload_ctrl_bench;

  localparam int ADDR_W    = 6;
  localparam int WORD_W    = 16;
  localparam int NUM_WORDS = 8;
  localparam int CLK_HALF  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [7:0]        reg_wdata = 8'h00;
  logic [7:0]        reg_rdata;
  logic              ee_cs, ee_sk, ee_di, ee_do;
  logic              net_en, cfg_wr_en, soft_rst;
  logic              ld_valid;
  logic              ld_ready = 1'b0;
  logic [ADDR_W-1:0] ld_addr;
  logic [WORD_W-1:0] ld_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  eeload_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CLK_HALF(CLK_HALF)
  ) u_eeload_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do), .net_en(net_en), .cfg_wr_en(cfg_wr_en), .soft_rst(soft_rst),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural EEPROM
  logic [WORD_W-1:0] mem [64];
  logic              force_en = 1'b0;
  logic              force_val = 1'b0;
  logic              model_do = 1'b0;
  int                bitcnt = 0;
  int                bitpos = 0;
  logic [8:0]        cmd = '0;
  int                cmd_idx = 0;

  assign ee_do = force_en ? force_val : model_do;

  always @(posedge ee_cs) begin
    bitcnt   = 0;
    cmd      = '0;
    model_do = 1'b0;
  end

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      if (bitcnt < 9) begin
        cmd = {cmd[7:0], ee_di};
        bitcnt++;
        if (bitcnt == 9) begin
          if (!force_en) begin
            chk(cmd[8:6] == 3'b110, "R7 command", {29'd0, cmd[8:6]}, 32'h6);
            chk(cmd[5:0] == 6'(cmd_idx), "R7 address", {26'd0, cmd[5:0]}, cmd_idx);
            cmd_idx++;
          end
          model_do = 1'b0;
          bitpos   = WORD_W - 1;
        end
      end else begin
        model_do = (bitpos >= 0) ? mem[cmd[5:0]][bitpos] : 1'b0;
        bitpos--;
        bitcnt++;
      end
    end
  end

  // ready driver, off the sampling edge
  bit rand_ready = 1'b0;
  always @(posedge clk) begin
    #1 ld_ready = rand_ready ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  // stream, pulse, pin and clock monitors (sampled at negedge)
  int                exp_idx = 0;
  int                soft_cnt = 0;
  logic              prev_soft = 1'b0;
  logic              prev_v = 1'b0, prev_r = 1'b0;
  logic [WORD_W-1:0] prev_d = '0;
  logic [ADDR_W-1:0] prev_a = '0;
  int                hrun = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_v && !prev_r)
        chk(ld_valid && ld_data == prev_d && ld_addr == prev_a, "R8 hold",
            {15'd0, ld_valid, ld_data}, {15'd0, 1'b1, prev_d});
      if (ld_valid && ld_ready) begin
        chk(ld_addr == ADDR_W'(exp_idx), "R8 address", ld_addr, exp_idx);
        chk(ld_data == mem[exp_idx[5:0]], "R7 data", ld_data, mem[exp_idx[5:0]]);
        exp_idx++;
      end
      prev_v = ld_valid; prev_r = ld_ready; prev_d = ld_data; prev_a = ld_addr;

      if (soft_rst) begin
        soft_cnt++;
        chk(reg_rdata == 8'h00, "R10 register at pulse", reg_rdata, 0);
        chk(!prev_soft, "R10 pulse width", 2, 1);
      end
      prev_soft = soft_rst;

      if (reg_rdata[7:6] == 2'b01) begin
        chk(reg_rdata[3:0] == {ee_cs, ee_sk, ee_di, ee_do}, "R9 pin view",
            reg_rdata[3:0], {ee_cs, ee_sk, ee_di, ee_do});
        if (ee_sk) hrun++;
        else if (hrun != 0) begin
          chk(hrun == CLK_HALF, "R11 sk high", hrun, CLK_HALF);
          hrun = 0;
        end
      end else begin
        hrun = 0;
      end
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_load(input bit randomize_ready, input int idle_cycles);
    int start_soft;
    rand_ready = randomize_ready;
    exp_idx = 0; cmd_idx = 0;
    start_soft = soft_cnt;
    wr(8'h40);
    chk(reg_rdata[7:6] == 2'b01, "R9 entered load", reg_rdata[7:6], 1);
    repeat (idle_cycles) @(negedge clk);
    wr(8'hC0);
    chk(reg_rdata[7:6] == 2'b01, "R9 write ignored", reg_rdata[7:6], 1);
    chk(cfg_wr_en == 1'b0, "R9 no unlock", cfg_wr_en, 0);
    while (soft_cnt == start_soft) @(negedge clk);
    @(negedge clk);
    chk(exp_idx == NUM_WORDS, "R7 word count", exp_idx, NUM_WORDS);
    chk(cmd_idx == NUM_WORDS, "R7 command count", cmd_idx, NUM_WORDS);
    chk(soft_cnt == start_soft + 1, "R10 one pulse", soft_cnt - start_soft, 1);
    chk(reg_rdata == 8'h00 && net_en && !ee_cs, "R10 back to run", reg_rdata, 0);
    rand_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [1:0] m;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom());

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1 pins", {ee_cs, ee_sk, ee_di}, 0);
    chk(net_en && !cfg_wr_en && !ld_valid && !soft_rst, "R1 controls",
        {net_en, cfg_wr_en, ld_valid, soft_rst}, 4'b1000);

    // run and unlock modes with random low bits
    for (int i = 0; i < 20; i++) begin
      m = (i % 2 == 0) ? 2'b00 : 2'b11;
      if (i > 3) m = 1'($urandom_range(0, 1)) ? 2'b11 : 2'b00;
      v = {m, 6'($urandom())};
      wr(v);
      chk(reg_rdata == {m, 6'b0}, "R2 readback", reg_rdata, {m, 6'b0});
      chk(cfg_wr_en == (m == 2'b11), "R3 unlock", cfg_wr_en, (m == 2'b11));
      chk({ee_cs, ee_sk, ee_di} == 3'b000, "R6 pins idle", {ee_cs, ee_sk, ee_di}, 0);
      chk(net_en, "R4 net enabled", net_en, 1);
    end

    // program mode with random pin values
    force_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      force_val = 1'($urandom_range(0, 1));
      v = {2'b10, 6'($urandom())};
      wr(v);
      chk({ee_cs, ee_sk, ee_di} == v[3:1], "R4 pins", {ee_cs, ee_sk, ee_di}, v[3:1]);
      chk(reg_rdata[7:1] == {2'b10, 2'b00, v[3:1]}, "R4 readback",
          reg_rdata[7:1], {2'b10, 2'b00, v[3:1]});
      chk(!net_en && !cfg_wr_en, "R4 disabled", {net_en, cfg_wr_en}, 0);
      chk(reg_rdata[0] == force_val, "R5 do view", reg_rdata[0], force_val);
      force_val = ~force_val;
      #1;
      chk(reg_rdata[0] == force_val, "R5 do live", reg_rdata[0], force_val);
    end

    force_val = 1'b0;
    wr(8'h81);
    chk(reg_rdata == 8'h80, "R5 write one ignored", reg_rdata, 8'h80);
    force_val = 1'b1;
    wr(8'h8E);
    chk(reg_rdata == 8'h8F, "R5 write zero ignored", reg_rdata, 8'h8F);
    wr(8'h0E);
    chk(reg_rdata == 8'h00 && {ee_cs, ee_sk, ee_di} == 3'b000, "R6 bits discarded",
        reg_rdata, 0);
    wr(8'hFF);
    chk(reg_rdata == 8'hC0, "R2 reserved ignored", reg_rdata, 8'hC0);
    chk(reg_rdata[3:0] == 4'h0, "R6 unlock low bits", reg_rdata[3:0], 0);
    force_en = 1'b0;

    // load from run mode with random back-pressure
    wr(8'h00);
    run_load(1'b1, 150);

    // load started straight from program mode, ready held high
    wr(8'h8A);
    run_load(1'b0, 40);

    // load from unlock mode, random back-pressure again
    wr(8'hC0);
    chk(cfg_wr_en, "R3 unlock before load", cfg_wr_en, 1);
    run_load(1'b1, 300);
    chk(!cfg_wr_en, "R3 locked after load", cfg_wr_en, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule